// File: doc/BRIEF.md
# Event-Reset Capture/Compare Timer

This block pairs a 16-bit up-counter with a 16-bit capture/compare register. The counter advances on every system clock or on synchronised rising edges of an external clock pin. The capture/compare register works in one of three ways. It can latch the counter value when a chosen edge pattern appears on a capture pin. It can raise a flag when the counter reaches its value. It can also send the counter back to zero on that match, so that the register sets the counter's period.

Software loads either byte of the counter or of the register through a narrow write port. Two sticky flags report a counter wrap and a capture/compare event. Each flag stays set until its clear pulse arrives. When the match clears the counter, the wrap flag is not raised. A bus write to the counter that lands in the same cycle as such a clear takes effect, and the clear is dropped.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, `tmr_val` and `ccr_val` are 0x0000 and both `ovf_flag` and `cc_flag` are 0.
- R2: With `clk_src_ext`=0, the counter adds one on every clock while `tmr_en`=1 and holds its value while `tmr_en`=0.
- R3: With `clk_src_ext`=1 and `tmr_en`=1, the counter adds one per rising edge of `ext_clk`, taken after a two-flop synchroniser. Once the counter is enabled, rising edges are ignored until a falling edge has been seen. Leaving this state (disable, or internal clock) rearms the wait.
- R4: `ovf_flag` goes to 1 when the counter steps from 0xFFFF to 0x0000 by counting. It stays at 1 until a one-cycle `ovf_clr` pulse. If a set and a clear fall in the same cycle, the set wins.
- R5: A write with `wr_en`=1 replaces one byte: `wr_addr` 0 is the counter low byte, 1 the counter high byte, 2 the register low byte, 3 the register high byte. A counter write replaces counting in that cycle.
- R6: When `cc_func`=01 (capture), a capture event copies the counter value into the register and sets `cc_flag`. `cap_edge` picks the event: 00 a falling edge of the synchronised `cap_in`, 01 a rising edge. A register write in the same cycle wins over the capture.
- R7: `cap_edge` 10 captures on every 4th rising edge and 11 on every 16th rising edge. The edge count restarts from zero whenever `cc_func` is not 01.
- R8: When `cc_func`=10 (compare), equality between the counter and the register sets `cc_flag`, and the counter keeps counting. `cc_flag` stays set until a `cc_clr` pulse.
- R9: When `cc_func`=11 (period), a match also sets the counter to 0x0000 on the next edge. With internal clocking the counter then cycles 0..P, where P is the register value. This clear never sets `ovf_flag`, even when P is 0xFFFF.
- R10: A counter byte write in the same cycle as a period clear loads the written byte, and the other byte is kept. The clear is ignored.
- R11: A match triggers at most once while the counter holds the same value. Clearing `cc_flag` during a standing match does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Counter enable |
| clk_src_ext | input | 1 | 1: count external clock edges, 0: count system clocks |
| ext_clk | input | 1 | External count clock (asynchronous) |
| cap_in | input | 1 | Capture pin (asynchronous) |
| cc_func | input | 2 | 00 idle, 01 capture, 10 compare, 11 period |
| cap_edge | input | 2 | Capture event select |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte address |
| wr_data | input | 8 | Byte write data |
| ovf_clr | input | 1 | Clear pulse for the wrap flag |
| cc_clr | input | 1 | Clear pulse for the capture/compare flag |
| tmr_val | output | 16 | Counter value |
| ccr_val | output | 16 | Capture/compare register value |
| ovf_flag | output | 1 | Sticky wrap flag |
| cc_flag | output | 1 | Sticky capture/compare flag |

## Verification
The hardest case to reach is a counter write that arrives in exactly the cycle in which a period match fires the clear. The bench stops the counter one below the register value. It writes the matching low byte, and on the very next cycle keeps the strobe up with a different byte. The match then lands on the write cycle. The wrap-versus-clear corner at 0xFFFF is reached by preloading the counter just below the top. The external clock arming is checked by starting the pin both low and high before enabling.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  typedef enum logic [1:0] {
    FN_IDLE    = 2'b00,
    FN_CAPTURE = 2'b01,
    FN_COMPARE = 2'b10,
    FN_PERIOD  = 2'b11
  } cc_func_e;

  typedef enum logic [1:0] {
    CE_FALL    = 2'b00,
    CE_RISE    = 2'b01,
    CE_RISE_Q  = 2'b10,
    CE_RISE_H  = 2'b11
  } cap_edge_e;

endpackage

// File: rtl/capcmp_sync_edge.sv
module capcmp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              last_q;
  logic              level;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = din;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], din};
    end
  endgenerate

  assign level = sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= level;
    end
  end

  assign rise = level & ~last_q;
  assign fall = ~level & last_q;

endmodule

// File: rtl/capcmp_extclk.sv
module capcmp_extclk (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_rise,
  input  logic ext_fall,
  output logic tick
);

  logic armed_q;
  logic armed_d;
  logic armed_en;

  always_comb begin
    armed_en = 1'b0;
    armed_d  = armed_q;
    if (!run) begin
      armed_en = armed_q;
      armed_d  = 1'b0;
    end else if (ext_fall) begin
      armed_en = 1'b1;
      armed_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_en) begin
      armed_q <= armed_d;
    end
  end

  assign tick = run & armed_q & ext_rise;

  // Every counted edge must be preceded by a falling edge while running
  AST_TICK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ext_rise && !$past(run)) |-> !tick); // R3

endmodule

// File: rtl/capcmp_counter.sv
module capcmp_counter #(
  parameter int TW = 16,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sp_clr,
  input  logic [TW/BW-1:0] wr_bytes,
  input  logic [BW-1:0]    wr_data,
  input  logic             ovf_clr,
  output logic [TW-1:0]    cnt,
  output logic             ovf
);

  localparam int NB = TW / BW;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;
  logic          ovf_q;
  logic          ovf_d;
  logic          wrap;
  logic          any_wr;

  assign any_wr = |wr_bytes;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (any_wr) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_bytes[b]) cnt_d[b*BW +: BW] = wr_data;
      end
    end else if (sp_clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + TW'(1);
      wrap  = (cnt_q == {TW{1'b1}});
    end
  end

  assign cnt_en = any_wr | sp_clr | tick;
  assign ovf_d  = (ovf_q & ~ovf_clr) | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bytes[0] |=> (cnt_q[BW-1:0] == $past(wr_data))); // R10
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_clr && !any_wr) |=> (cnt_q == '0)); // R9
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ($past(cnt_q) == {TW{1'b1}} && cnt_q == '0)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q); // R4

endmodule

// File: rtl/capcmp_ccreg.sv
module capcmp_ccreg
  import capcmp_pkg::*;
#(
  parameter int TW   = 16,
  parameter int BW   = 8,
  parameter int PS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       func,
  input  logic [1:0]       edge_sel,
  input  logic             cap_rise,
  input  logic             cap_fall,
  input  logic [TW-1:0]    tmr,
  input  logic [TW/BW-1:0] wr_bytes,
  input  logic [BW-1:0]    wr_data,
  input  logic             flag_clr,
  output logic [TW-1:0]    ccr,
  output logic             flag,
  output logic             sp_clr
);

  localparam int NB       = TW / BW;
  localparam int PS_SHORT = PS_W / 2;

  cc_func_e  fn;
  cap_edge_e esel;

  logic [TW-1:0]   ccr_q;
  logic [TW-1:0]   ccr_d;
  logic            ccr_en;
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] ps_d;
  logic            ps_en;
  logic            match;
  logic            match_q;
  logic            cmp_mode;
  logic            trig;
  logic            cap_hit;
  logic            cap_evt;
  logic            flag_q;
  logic            flag_d;
  logic            any_wr;

  assign fn     = cc_func_e'(func);
  assign esel   = cap_edge_e'(edge_sel);
  assign any_wr = |wr_bytes;

  // Edge prescaler for the capture path
  always_comb begin
    ps_en = 1'b0;
    ps_d  = ps_q;
    if (fn != FN_CAPTURE) begin
      ps_en = |ps_q;
      ps_d  = '0;
    end else if (cap_rise) begin
      ps_en = 1'b1;
      ps_d  = ps_q + PS_W'(1);
    end
  end

  always_comb begin
    unique case (esel)
      CE_FALL:   cap_hit = cap_fall;
      CE_RISE:   cap_hit = cap_rise;
      CE_RISE_Q: cap_hit = cap_rise && (ps_q[PS_SHORT-1:0] == {PS_SHORT{1'b1}});
      default:   cap_hit = cap_rise && (ps_q == {PS_W{1'b1}});
    endcase
  end

  assign cap_evt = cap_hit && (fn == FN_CAPTURE);

  // Compare path: one trigger per arrival at a matching value
  assign match    = (tmr == ccr_q);
  assign cmp_mode = (fn == FN_COMPARE) || (fn == FN_PERIOD);
  assign trig     = match && !match_q && cmp_mode;
  assign sp_clr   = trig && (fn == FN_PERIOD);

  always_comb begin
    ccr_d  = ccr_q;
    ccr_en = 1'b0;
    if (any_wr) begin
      ccr_en = 1'b1;
      for (int b = 0; b < NB; b++) begin
        if (wr_bytes[b]) ccr_d[b*BW +: BW] = wr_data;
      end
    end else if (cap_evt) begin
      ccr_en = 1'b1;
      ccr_d  = tmr;
    end
  end

  assign flag_d = (flag_q & ~flag_clr) | trig | cap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q <= '0;
    end else if (ccr_en) begin
      ccr_q <= ccr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
    end else if (ps_en) begin
      ps_q <= ps_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      match_q <= match;
      flag_q  <= flag_d;
    end
  end

  assign ccr  = ccr_q;
  assign flag = flag_q;

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !any_wr) |=> (ccr_q == $past(tmr))); // R6
  AST_SINGLE_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R8
  AST_PRESCALE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fn != FN_CAPTURE) |=> (ps_q == '0)); // R7

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int TW        = 16,
  parameter int BW        = 8,
  parameter int SYNC_STGS = 2,
  parameter int PS_W      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tmr_en,
  input  logic                         clk_src_ext,
  input  logic                         ext_clk,
  input  logic                         cap_in,
  input  logic [1:0]                   cc_func,
  input  logic [1:0]                   cap_edge,
  input  logic                         wr_en,
  input  logic [$clog2(2*(TW/BW))-1:0] wr_addr,
  input  logic [BW-1:0]                wr_data,
  input  logic                         ovf_clr,
  input  logic                         cc_clr,
  output logic [TW-1:0]                tmr_val,
  output logic [TW-1:0]                ccr_val,
  output logic                         ovf_flag,
  output logic                         cc_flag
);

  localparam int NB = TW / BW;
  localparam int AW = $clog2(2 * NB);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [NB-1:0] wr_tmr;
  logic [NB-1:0] wr_ccr;
  logic          ext_rise;
  logic          ext_fall;
  logic          cap_rise;
  logic          cap_fall;
  logic          ext_run;
  logic          ext_tick;
  logic          tick;
  logic          sp_clr;

  // Reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  generate
    for (genvar i = 0; i < NB; i++) begin : g_dec
      assign wr_tmr[i] = wr_en && (wr_addr == AW'(i));
      assign wr_ccr[i] = wr_en && (wr_addr == AW'(NB + i));
    end
  endgenerate

  capcmp_sync_edge #(.STAGES(SYNC_STGS)) u_ext_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (ext_clk),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  capcmp_sync_edge #(.STAGES(SYNC_STGS)) u_cap_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (cap_in),
    .rise  (cap_rise),
    .fall  (cap_fall)
  );

  assign ext_run = tmr_en & clk_src_ext;

  capcmp_extclk u_extclk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (ext_run),
    .ext_rise (ext_rise),
    .ext_fall (ext_fall),
    .tick     (ext_tick)
  );

  assign tick = tmr_en & (clk_src_ext ? ext_tick : 1'b1);

  capcmp_counter #(.TW(TW), .BW(BW)) u_counter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick),
    .sp_clr   (sp_clr),
    .wr_bytes (wr_tmr),
    .wr_data  (wr_data),
    .ovf_clr  (ovf_clr),
    .cnt      (tmr_val),
    .ovf      (ovf_flag)
  );

  capcmp_ccreg #(.TW(TW), .BW(BW), .PS_W(PS_W)) u_ccreg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .func     (cc_func),
    .edge_sel (cap_edge),
    .cap_rise (cap_rise),
    .cap_fall (cap_fall),
    .tmr      (tmr_val),
    .wr_bytes (wr_ccr),
    .wr_data  (wr_data),
    .flag_clr (cc_clr),
    .ccr      (ccr_val),
    .flag     (cc_flag),
    .sp_clr   (sp_clr)
  );

  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ext_run && !ext_tick && !(|wr_tmr) && !sp_clr) |=> $stable(tmr_val)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!tmr_en && !(|wr_tmr) && !sp_clr) |=> $stable(tmr_val)); // R2

endmodule

// File: tb/capcmp_timer_test.sv
module capcmp_timer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tmr_en;
  logic        clk_src_ext;
  logic        ext_clk;
  logic        cap_in;
  logic [1:0]  cc_func;
  logic [1:0]  cap_edge;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        ovf_clr;
  logic        cc_clr;
  logic [15:0] tmr_val;
  logic [15:0] ccr_val;
  logic        ovf_flag;
  logic        cc_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capcmp_timer uut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .clk_src_ext(clk_src_ext),
    .ext_clk(ext_clk), .cap_in(cap_in), .cc_func(cc_func), .cap_edge(cap_edge),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .cc_clr(cc_clr), .tmr_val(tmr_val), .ccr_val(ccr_val),
    .ovf_flag(ovf_flag), .cc_flag(cc_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_tmr(input logic [15:0] v);
    bus_wr(2'd1, v[15:8]);
    bus_wr(2'd0, v[7:0]);
  endtask

  task automatic set_ccr(input logic [15:0] v);
    bus_wr(2'd3, v[15:8]);
    bus_wr(2'd2, v[7:0]);
  endtask

  task automatic clr_flags();
    ovf_clr = 1'b1; cc_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0; cc_clr = 1'b0;
  endtask

  task automatic cap_level(input logic v);
    cap_in = v;
    wait_n(4);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tmr_en = 1'b0; clk_src_ext = 1'b0; ext_clk = 1'b0;
    cap_in = 1'b0; cc_func = 2'b00; cap_edge = 2'b01; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; ovf_clr = 1'b0; cc_clr = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    check("R1 tmr", tmr_val, 0);
    check("R1 ccr", ccr_val, 0);
    check("R1 ovf", ovf_flag, 0);
    check("R1 ccf", cc_flag, 0);

    // R5 byte writes
    set_tmr(16'h1234);
    check("R5 tmr word", tmr_val, 16'h1234);
    bus_wr(2'd1, 8'hAB);
    check("R5 tmr hi only", tmr_val, 16'hAB34);
    set_ccr(16'h5678);
    bus_wr(2'd2, 8'h9C);
    check("R5 ccr lo only", ccr_val, 16'h569C);

    // R2 internal counting sweep
    for (int s = 0; s < 4; s++) begin
      for (int k = 1; k <= 9; k++) begin
        logic [15:0] start;
        start = 16'h0100 * s + 16'h0011 * k;
        set_tmr(start);
        tmr_en = 1'b1;
        wait_n(k);
        tmr_en = 1'b0;
        check("R2 count", tmr_val, start + k);
        wait_n(2);
        check("R2 hold", tmr_val, start + k);
      end
    end

    // R4 wrap
    clr_flags();
    set_tmr(16'hFFFE);
    tmr_en = 1'b1;
    wait_n(1);
    check("R4 before wrap", ovf_flag, 0);
    wait_n(1);
    tmr_en = 1'b0;
    check("R4 wrap value", tmr_val, 0);
    check("R4 set", ovf_flag, 1);
    wait_n(3);
    check("R4 sticky", ovf_flag, 1);
    clr_flags();
    check("R4 cleared", ovf_flag, 0);

    // R3 external clock, pin starting low: first rise ignored
    clk_src_ext = 1'b1;
    for (int n = 1; n <= 5; n++) begin
      ext_clk = 1'b0; wait_n(4);
      set_tmr(16'h0000);
      tmr_en = 1'b1;
      for (int p = 0; p < n; p++) begin
        ext_clk = 1'b1; wait_n(4);
        ext_clk = 1'b0; wait_n(4);
      end
      tmr_en = 1'b0;
      check("R3 start low", tmr_val, n - 1);
    end
    // R3 pin starting high: falling edge arms, all rises count
    for (int n = 1; n <= 5; n++) begin
      ext_clk = 1'b1; wait_n(4);
      set_tmr(16'h0000);
      tmr_en = 1'b1;
      ext_clk = 1'b0; wait_n(4);
      for (int p = 0; p < n; p++) begin
        ext_clk = 1'b1; wait_n(4);
        ext_clk = 1'b0; wait_n(4);
      end
      tmr_en = 1'b0;
      check("R3 start high", tmr_val, n);
    end
    clk_src_ext = 1'b0;

    // R6 capture on rising / falling edge, timer frozen
    cc_func = 2'b01; cap_edge = 2'b01;
    clr_flags();
    set_tmr(16'h1234);
    cap_level(1'b1);
    check("R6 rise capture", ccr_val, 16'h1234);
    check("R6 flag", cc_flag, 1);
    set_tmr(16'h1299);
    cap_level(1'b0);
    check("R6 fall ignored in rise mode", ccr_val, 16'h1234);
    cap_edge = 2'b00;
    set_tmr(16'h2345);
    cap_level(1'b1);
    check("R6 rise ignored in fall mode", ccr_val, 16'h1234);
    cap_level(1'b0);
    check("R6 fall capture", ccr_val, 16'h2345);

    // R7 prescaled capture sweep
    for (int m = 0; m < 2; m++) begin
      int div;
      logic [15:0] prev;
      div = (m == 0) ? 4 : 16;
      cap_edge = (m == 0) ? 2'b10 : 2'b11;
      cc_func = 2'b00; wait_n(1);
      cc_func = 2'b01;
      prev = ccr_val;
      for (int k = 1; k <= div; k++) begin
        set_tmr(16'h0A00 + 16'(k) + 16'(m * 32));
        cap_level(1'b1);
        cap_level(1'b0);
        if (k < div) check("R7 no capture yet", ccr_val, prev);
        else         check("R7 capture at nth", ccr_val, 16'h0A00 + 16'(k) + 16'(m * 32));
      end
    end
    // R7 count restarts when leaving capture mode
    cap_edge = 2'b10;
    cc_func = 2'b00; wait_n(1); cc_func = 2'b01;
    set_tmr(16'h0B01);
    cap_level(1'b1); cap_level(1'b0);
    cap_level(1'b1); cap_level(1'b0);
    cc_func = 2'b00; wait_n(1); cc_func = 2'b01;
    for (int k = 1; k <= 3; k++) begin
      cap_level(1'b1); cap_level(1'b0);
    end
    check("R7 restart no capture", ccr_val, 16'h0A30);
    cap_level(1'b1); cap_level(1'b0);
    check("R7 restart capture", ccr_val, 16'h0B01);
    cc_func = 2'b00;

    // R8 compare without clearing
    set_tmr(16'h0000);
    set_ccr(16'h0003);
    clr_flags();
    cc_func = 2'b10;
    tmr_en = 1'b1;
    wait_n(2);
    check("R8 no flag before match", cc_flag, 0);
    wait_n(4);
    tmr_en = 1'b0;
    check("R8 keeps counting", tmr_val, 6);
    check("R8 flag", cc_flag, 1);
    cc_func = 2'b00;

    // R9 period sweep
    for (int p = 1; p <= 12; p++) begin
      int t;
      set_tmr(16'h0000);
      set_ccr(16'(p));
      clr_flags();
      cc_func = 2'b11; tmr_en = 1'b1;
      t = 0;
      for (int c = 0; c < 3 * (p + 1); c++) begin
        @(negedge clk);
        t = (t == p) ? 0 : t + 1;
        check("R9 period sequence", tmr_val, t);
      end
      tmr_en = 1'b0; cc_func = 2'b00;
      check("R9 flag", cc_flag, 1);
      check("R9 no ovf", ovf_flag, 0);
    end
    // R9 clear at 0xFFFF does not flag a wrap
    set_tmr(16'hFFFD);
    set_ccr(16'hFFFF);
    clr_flags();
    cc_func = 2'b11; tmr_en = 1'b1;
    wait_n(2);
    check("R9 top reached", tmr_val, 16'hFFFF);
    wait_n(1);
    check("R9 cleared at top", tmr_val, 0);
    check("R9 no ovf at top", ovf_flag, 0);
    wait_n(1);
    tmr_en = 1'b0; cc_func = 2'b00;
    check("R9 counts on", tmr_val, 1);

    // R10 write coincides with period clear
    set_tmr(16'h0104);
    set_ccr(16'h0005);
    bus_wr(2'd1, 8'h00);
    clr_flags();
    cc_func = 2'b11;
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h05;
    @(negedge clk);
    wr_data = 8'h33;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 write wins", tmr_val, 16'h0033);
    check("R10 match flagged", cc_flag, 1);
    cc_func = 2'b00;

    // R11 standing match triggers once
    cc_func = 2'b10;
    set_ccr(16'h0099);
    set_tmr(16'h0040);
    clr_flags();
    bus_wr(2'd2, 8'h40);
    wait_n(1);
    check("R11 first trigger", cc_flag, 1);
    clr_flags();
    wait_n(5);
    check("R11 no retrigger", cc_flag, 0);
    cc_func = 2'b00;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule